// File: doc/BRIEF.md
# Masked Peripheral Interrupt Controller

This block gathers interrupt requests from the peripherals around a processor and reduces them to one interrupt line. The sources are up to ten external lines, the flag sets of two serial channels, the single-bit and multi-bit flags of a memory error-correction unit, and the read and write flags of an address-protection unit. Each source sets a sticky pending bit in a 32-bit status register. Software reads that register to poll devices even while every interrupt is disabled.

A 32-bit enable register selects which pending bits may interrupt. The cause register is the status register ANDed with the enable register, so it shows only the pending bits that need service. Writing ones to the status register clears those pending bits. Writing ones to the cause register sets them, which lets software raise any interrupt itself. The interrupt output is the registered OR of the cause register.

The register port is a plain single-cycle bus. A write takes effect at the clock edge where `bus_wr` is high. A read returns the register picked by `bus_addr` combinationally. Register codes on `bus_addr`: 0 is status, 1 is cause, 2 is enable, and 3 reads zero and ignores writes.

Top module: `pirq_ctrl`

## Requirements
- R1: After a clock edge with `rst_n` low, status, cause and enable all read zero and `irq_out` is low.
- R2: A source that is high at a clock edge sets its status bit at that edge, whatever the enable register holds.
- R3: Bit map: external line k sets bit k (k = 0..9). The serial channel 0 flag vector bit j sets status bit 11+j, and the serial channel 1 flag vector bit j sets status bit 17+j (j = 0..4; flag bit 4 is receive-ready down to flag bit 0, framing error). Write violation sets bit 22, read violation bit 23, the multi-bit error flag bit 30 and the single-bit error flag bit 31.
- R4: A status bit stays set after its source goes low, until software clears it.
- R5: Writing the status register clears each bit written as 1. Bits written as 0 keep their value.
- R6: If a source is high in the same cycle as a write that clears its bit, the bit stays set.
- R7: The cause register reads as status AND enable.
- R8: Writing the cause register sets each status bit written as 1. Bits written as 0 are unchanged.
- R9: The enable register reads back the value written to it, except for the reserved bits.
- R10: Reserved bits 10, 16 and 24 to 29 read as zero in all three registers, and writes to them have no effect.
- R11: `irq_out` is high one clock after the cause register is non-zero, and low one clock after it becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_irq | input | N_EXT | External interrupt lines |
| uart0_flags | input | 5 | Serial channel 0 flags, receive-ready in bit 4 down to framing error in bit 0 |
| uart1_flags | input | 5 | Serial channel 1 flags, same order as channel 0 |
| ecc_single | input | 1 | Single-bit corrected-error flag |
| ecc_multi | input | 1 | Multi-bit error flag |
| viol_wr | input | 1 | Write access-violation flag |
| viol_rd | input | 1 | Read access-violation flag |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 status, 1 cause, 2 enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach from the ports is a clear that collides with a live source in the same cycle, because the source has to be held high across the very edge on which the status write lands. The bench holds an external line high, issues the clearing write while the line is still high, and checks that the bit survives. It then releases the line and shows that the same write now clears the bit. The one-cycle lag of `irq_out` is checked on both sides of an enable write, by sampling before and after the extra register stage.

// File: rtl/pirq_pkg.sv
// Package: shared constants and bit-map helpers for the peripheral
// interrupt controller. Assumes a 32-bit register width.
package pirq_pkg;
    localparam int REG_W      = 32;
    localparam int FLAG_W     = 5;
    localparam int MAX_EXT    = 10;
    localparam int U0_LSB     = 11;
    localparam int U1_LSB     = 17;
    localparam int VWR_BIT    = 22;
    localparam int VRD_BIT    = 23;
    localparam int EMULTI_BIT = 30;
    localparam int ESNGL_BIT  = 31;

    localparam logic [1:0] SEL_STATUS = 2'd0;
    localparam logic [1:0] SEL_CAUSE  = 2'd1;
    localparam logic [1:0] SEL_ENABLE = 2'd2;

    // Computes the set of live (non-reserved) bits for a given line count.
    function automatic logic [REG_W-1:0] live_bits(input int n_ext);
        logic [REG_W-1:0] v;
        v = '0;
        for (int k = 0; k < n_ext; k++) v[k] = 1'b1;
        for (int j = 0; j < FLAG_W; j++) begin
            v[U0_LSB+j] = 1'b1;
            v[U1_LSB+j] = 1'b1;
        end
        v[VWR_BIT]    = 1'b1;
        v[VRD_BIT]    = 1'b1;
        v[EMULTI_BIT] = 1'b1;
        v[ESNGL_BIT]  = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/pirq_src_map.sv
// Module: places each request source on its fixed status bit.
// Assumes N_EXT <= 10; unused positions are driven low.
module pirq_src_map
    import pirq_pkg::*;
#(
    parameter int N_EXT = 10
) (
    input  logic [N_EXT-1:0]  ext_irq,
    input  logic [FLAG_W-1:0] uart0_flags,
    input  logic [FLAG_W-1:0] uart1_flags,
    input  logic              ecc_single,
    input  logic              ecc_multi,
    input  logic              viol_wr,
    input  logic              viol_rd,
    output logic [REG_W-1:0]  req_vec
);
    logic [REG_W-1:0] ext_part;
    logic [REG_W-1:0] dev_part;

    // External lines occupy the bottom bits.
    for (genvar k = 0; k < REG_W; k++) begin : g_ext
        if (k < N_EXT) begin : g_on
            assign ext_part[k] = ext_irq[k];
        end else begin : g_off
            assign ext_part[k] = 1'b0;
        end
    end

    // Device flags placed at their fixed positions.
    always_comb begin
        dev_part = '0;
        dev_part[U0_LSB +: FLAG_W] = uart0_flags;
        dev_part[U1_LSB +: FLAG_W] = uart1_flags;
        dev_part[VWR_BIT]          = viol_wr;
        dev_part[VRD_BIT]          = viol_rd;
        dev_part[EMULTI_BIT]       = ecc_multi;
        dev_part[ESNGL_BIT]        = ecc_single;
    end

    assign req_vec = ext_part | dev_part;
endmodule

// File: rtl/pirq_status_bank.sv
// Module: sticky pending bits. Per bit: set by the source or by a software
// force, cleared by a write-one-to-clear; setting wins over clearing.
// Assumes LIVE marks the bits that exist; the others are tied to zero.
module pirq_status_bank
    import pirq_pkg::*;
#(
    parameter logic [REG_W-1:0] LIVE = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_vec,
    input  logic [REG_W-1:0] clr_vec,
    output logic [REG_W-1:0] stat_q
);
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (LIVE[i]) begin : g_live
            logic bit_q;
            // Update one pending bit, set taking priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)          bit_q <= 1'b0;
                else if (set_vec[i]) bit_q <= 1'b1;
                else if (clr_vec[i]) bit_q <= 1'b0;
            end
            assign stat_q[i] = bit_q;
        end else begin : g_rsv
            assign stat_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/pirq_enable_reg.sv
// Module: interrupt enable register; only live bits are stored.
// Assumes a single-cycle write strobe.
module pirq_enable_reg
    import pirq_pkg::*;
#(
    parameter logic [REG_W-1:0] LIVE = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] en_q
);
    // Load the enable bits on a write, keeping reserved bits at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= wdata & LIVE;
    end
endmodule

// File: rtl/pirq_ctrl.sv
// Module: top of the masked peripheral interrupt controller. Decodes the
// register bus, holds status and enable, forms cause and the registered
// interrupt output. Assumes a single-cycle bus with combinational read.
module pirq_ctrl
    import pirq_pkg::*;
#(
    parameter int N_EXT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EXT-1:0]  ext_irq,
    input  logic [FLAG_W-1:0] uart0_flags,
    input  logic [FLAG_W-1:0] uart1_flags,
    input  logic              ecc_single,
    input  logic              ecc_multi,
    input  logic              viol_wr,
    input  logic              viol_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq_out
);
    localparam logic [REG_W-1:0] LIVE = live_bits(N_EXT);

    logic [REG_W-1:0] req_vec;
    logic [REG_W-1:0] status_q;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] cause_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] frc_vec;
    logic             en_wr;

    pirq_src_map #(.N_EXT(N_EXT)) u_map (
        .ext_irq     (ext_irq),
        .uart0_flags (uart0_flags),
        .uart1_flags (uart1_flags),
        .ecc_single  (ecc_single),
        .ecc_multi   (ecc_multi),
        .viol_wr     (viol_wr),
        .viol_rd     (viol_rd),
        .req_vec     (req_vec)
    );

    // Decode the bus write into clear, force and enable-load actions.
    always_comb begin
        clr_vec = '0;
        frc_vec = '0;
        en_wr   = 1'b0;
        if (bus_wr) begin
            case (bus_addr)
                SEL_STATUS: clr_vec = bus_wdata;
                SEL_CAUSE:  frc_vec = bus_wdata;
                SEL_ENABLE: en_wr   = 1'b1;
                default:    ;
            endcase
        end
    end

    pirq_status_bank #(.LIVE(LIVE)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (req_vec | frc_vec),
        .clr_vec (clr_vec),
        .stat_q  (status_q)
    );

    pirq_enable_reg #(.LIVE(LIVE)) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (en_wr),
        .wdata (bus_wdata),
        .en_q  (mask_q)
    );

    assign cause_vec = status_q & mask_q;

    // Select the register seen on the read bus.
    always_comb begin
        case (bus_addr)
            SEL_STATUS: bus_rdata = status_q;
            SEL_CAUSE:  bus_rdata = cause_vec;
            SEL_ENABLE: bus_rdata = mask_q;
            default:    bus_rdata = '0;
        endcase
    end

    // Register the OR of all enabled pending bits as the interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= |cause_vec;
    end
endmodule

// File: rtl/pirq_ctrl_chk.sv
// Module: assertion checker for pirq_ctrl, attached with bind.
// Assumes the bound instance exposes req_vec, status_q and mask_q.
module pirq_ctrl_chk
    import pirq_pkg::*;
#(
    parameter int N_EXT = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [REG_W-1:0] bus_wdata,
    input logic [REG_W-1:0] bus_rdata,
    input logic             irq_out,
    input logic [REG_W-1:0] req_vec,
    input logic [REG_W-1:0] status_q,
    input logic [REG_W-1:0] mask_q
);
    localparam logic [REG_W-1:0] RSV = ~live_bits(N_EXT);

    logic [REG_W-1:0] clr_now;
    logic [REG_W-1:0] frc_now;
    assign clr_now = (bus_wr && bus_addr == SEL_STATUS) ? bus_wdata : '0;
    assign frc_now = (bus_wr && bus_addr == SEL_CAUSE)  ? bus_wdata : '0;

    // R6 and R2: a source high at an edge leaves its bit set after it.
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(req_vec) & ~RSV & ~status_q) == '0));

    // R4: a set bit with no clear written stays set.
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(status_q) & ~$past(clr_now) & ~status_q) == '0));

    // R5: a cleared bit with no set source or force goes to zero.
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((status_q & $past(clr_now)
                           & ~$past(req_vec) & ~$past(frc_now)) == '0));

    // R8: a forced bit reads set after the write.
    a_r8_force: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(frc_now) & ~RSV & ~status_q) == '0));

    // R10: reserved bits never appear on the read bus.
    a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & RSV) == '0);

    // R7: a cause read never shows a bit that is not both pending and enabled.
    a_r7_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == SEL_CAUSE) |-> ((bus_rdata & ~(status_q & mask_q)) == '0));

    // R11: the interrupt follows the OR of enabled pending bits by one clock.
    a_r11_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_out == (|($past(status_q) & $past(mask_q)))));
endmodule

bind pirq_ctrl pirq_ctrl_chk #(.N_EXT(N_EXT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .req_vec   (req_vec),
    .status_q  (status_q),
    .mask_q    (mask_q)
);

// File: tb/pirq_ctrl_bench.sv
// Directed bench for pirq_ctrl: one task per scenario, each checking itself.
module pirq_ctrl_bench;
    localparam int CLK_P = 10;
    localparam logic [31:0] LIVE = 32'hC0FE_FBFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  ext_irq = '0;
    logic [4:0]  uart0_flags = '0;
    logic [4:0]  uart1_flags = '0;
    logic        ecc_single = 1'b0;
    logic        ecc_multi = 1'b0;
    logic        viol_wr = 1'b0;
    logic        viol_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    pirq_ctrl #(.N_EXT(10)) u_pirq_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq),
        .uart0_flags(uart0_flags), .uart1_flags(uart1_flags),
        .ecc_single(ecc_single), .ecc_multi(ecc_multi),
        .viol_wr(viol_wr), .viol_rd(viol_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write at the next edge; returns at the following falling edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic clear_all();
        wr(2'd2, 32'h0);
        wr(2'd0, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); check("R1 status", v, 0);
        rd(2'd1, v); check("R1 cause", v, 0);
        rd(2'd2, v); check("R1 enable", v, 0);
        check("R1 irq", {31'b0, irq_out}, 0);
    endtask

    // Pulses one source for one cycle; expects exactly bit b in status.
    task automatic pulse_check(input int src, input int b);
        logic [31:0] v;
        @(negedge clk);
        case (src)
            0: ext_irq[b] = 1'b1;
            1: uart0_flags[b-11] = 1'b1;
            2: uart1_flags[b-17] = 1'b1;
            3: viol_wr = 1'b1;
            4: viol_rd = 1'b1;
            5: ecc_multi = 1'b1;
            default: ecc_single = 1'b1;
        endcase
        @(negedge clk);
        ext_irq = '0; uart0_flags = '0; uart1_flags = '0;
        viol_wr = 0; viol_rd = 0; ecc_multi = 0; ecc_single = 0;
        rd(2'd0, v); check($sformatf("R3 R2 map bit %0d", b), v, 32'h1 << b);
        rd(2'd1, v); check("R2 cause masked", v, 0);
        wr(2'd0, 32'hFFFF_FFFF);
    endtask

    task automatic t_map();
        for (int k = 0; k < 10; k++) pulse_check(0, k);
        for (int j = 11; j < 16; j++) pulse_check(1, j);
        for (int j = 17; j < 22; j++) pulse_check(2, j);
        pulse_check(3, 22);
        pulse_check(4, 23);
        pulse_check(5, 30);
        pulse_check(6, 31);
        check("R2 irq stays low masked", {31'b0, irq_out}, 0);
    endtask

    task automatic t_sticky_w1c();
        logic [31:0] v;
        @(negedge clk); ext_irq = 10'b11_0000_0011;
        @(negedge clk); ext_irq = '0;
        repeat (4) @(negedge clk);
        rd(2'd0, v); check("R4 sticky", v, 32'h303);
        wr(2'd0, 32'h0000_0101);
        rd(2'd0, v); check("R5 partial clear", v, 32'h202);
        wr(2'd0, 32'h0);
        rd(2'd0, v); check("R5 zero write keeps", v, 32'h202);
        clear_all();
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        @(negedge clk); ext_irq[2] = 1'b1;
        wr(2'd0, 32'h4);
        rd(2'd0, v); check("R6 set wins over clear", v, 32'h4);
        ext_irq[2] = 1'b0;
        wr(2'd0, 32'h4);
        rd(2'd0, v); check("R6 clear after release", v, 0);
    endtask

    task automatic t_cause_enable();
        logic [31:0] v;
        wr(2'd1, 32'h8000_A005);
        rd(2'd0, v); check("R8 force sets status", v, 32'h8000_A005);
        wr(2'd1, 32'h0);
        rd(2'd0, v); check("R8 zero force no change", v, 32'h8000_A005);
        wr(2'd2, 32'h0000_8004);
        rd(2'd2, v); check("R9 enable readback", v, 32'h0000_8004);
        rd(2'd1, v); check("R7 cause and", v, 32'h0000_8004);
        wr(2'd2, 32'hFFFF_0000);
        rd(2'd1, v); check("R7 cause other mask", v, 32'h8000_0000);
        clear_all();
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, v); check("R10 enable reserved", v, LIVE);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd0, v); check("R10 status reserved", v, LIVE);
        rd(2'd1, v); check("R10 cause reserved", v, LIVE);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, v); check("R10 unused address", v, 0);
        clear_all();
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(2'd1, 32'h0000_0020);
        @(negedge clk);
        check("R11 irq low when disabled", {31'b0, irq_out}, 0);
        wr(2'd2, 32'h0000_0020);
        check("R11 irq not yet high", {31'b0, irq_out}, 0);
        @(negedge clk);
        check("R11 irq high", {31'b0, irq_out}, 1);
        wr(2'd0, 32'h0000_0020);
        check("R11 irq not yet low", {31'b0, irq_out}, 1);
        @(negedge clk);
        check("R11 irq low", {31'b0, irq_out}, 0);
        rd(2'd0, v); check("R5 cleared", v, 0);
        clear_all();
    endtask

    task automatic t_reset_again();
        logic [31:0] v;
        wr(2'd1, 32'h0000_0001);
        wr(2'd2, 32'h0000_0001);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(2'd0, v); check("R1 status after reset", v, 0);
        rd(2'd2, v); check("R1 enable after reset", v, 0);
        check("R1 irq after reset", {31'b0, irq_out}, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_sticky_w1c();
        t_set_wins();
        t_cause_enable();
        t_reserved();
        t_irq();
        t_reset_again();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule